// File: doc/BRIEF.md
# Multi-register transfer address sequencer

This block turns one block-transfer command into a series of single-word memory requests. A command carries a register-list mask, a base address, the index of the base register, a load/store select and a request to update the base register afterwards. The sequencer walks the list from the highest set index down to the lowest, giving each listed register one word address. Addresses descend from the word-aligned base in 4-byte steps, and each request is offered on a valid/ready port.

When the last request has been taken, the block raises a one-cycle `done` pulse. With that pulse it reports whether the command was illegal and, if it was asked for, the value the base register should take. It also rules on a load into the program-counter slot (index 15). The returned word must have bit 0 set. If it does, the word with bit 0 cleared is given as a branch target; if it does not, the command faults.

The block holds no memory, no register file and no condition flags, and it never drives any flag. An illegal command produces no memory request at all. It ends with a fault pulse one cycle after it is accepted.

Top module: `mrx_seq`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress and no `done` pulse is showing. A `cmd_valid` seen while `cmd_ready` is low has no effect on the requests or the results.
- R2: Transfer requests appear in strictly decreasing register index, one per set bit of the mask, and never more than one per clock.
- R3: The first request uses the base address with its two low bits forced to 0. Each later request uses an address exactly 4 lower than the one before, so the lowest listed register gets base minus 4*(n-1), where n is the number of set mask bits.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_idx`, `mem_addr` and `mem_load` keep their values on the next cycle.
- R5: `done` is high for exactly one cycle. For a legal command it comes in the cycle after the handshake of the last request; for an illegal one it comes in the cycle after acceptance.
- R6: When writeback is requested and the command ends without fault, `wb_valid` is high with `done`, and `wb_value` equals the aligned base minus 4*(n-1). `wb_valid` is low otherwise.
- R7: An all-zero mask gives `fault` with `done`, and no request is issued.
- R8: A base-register index of 15, or a mask with bit 13 set, gives `fault` with `done`, and no request is issued.
- R9: A store whose mask has bit 15 set, or a load whose mask has both bits 14 and 15 set, gives `fault` with `done`, and no request is issued.
- R10: Writeback requested with mask bit [`cmd_rn`] set gives `fault` with `done`, and no request is issued.
- R11: On a load, the `mem_rdata` returned for index 15 is checked. If bit 0 is 1, `br_valid` is high with `done` and `br_target` is that word with bit 0 cleared. If bit 0 is 0, `fault` is high and `br_valid` stays low.
- R12: `mem_load` equals the `cmd_load` of the accepted command on every request (1 = load, 0 = store).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid |
| cmd_mask | input | 16 | Register list, bit i selects register i |
| cmd_base | input | 32 | Base address |
| cmd_rn | input | 4 | Base-register index |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Update the base register at the end |
| mem_valid | output | 1 | Transfer request valid |
| mem_ready | input | 1 | Memory port takes the request |
| mem_idx | output | 4 | Register index of the request |
| mem_addr | output | 32 | Word address of the request |
| mem_load | output | 1 | Direction of the request |
| mem_rdata | input | 32 | Load data, valid with the handshake |
| done | output | 1 | One-cycle end-of-command pulse |
| fault | output | 1 | Illegal command, valid with done |
| wb_valid | output | 1 | Writeback value present, with done |
| wb_value | output | 32 | New base-register value |
| br_valid | output | 1 | Branch request, with done |
| br_target | output | 32 | Halfword-aligned branch target |

## Verification
The bench builds the block with its default parameters: a 16-entry list, 32-bit addresses and a 4-byte step. With these values the special indices 13, 14 and 15 all fall inside the list, so every encoding rule can be reached. A full list with bits 15 and 12..0 drives the address walk across all of its width, and an unaligned base exercises the forcing of the low bits. The memory port's `mem_ready` is driven both always-high and from a pseudo-random stream. This mixes stalls of varying length into long and single-entry lists alike, and a command offered during a transfer checks that it is ignored.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [1:0] {
    MRX_IDLE = 2'd0,
    MRX_XFER = 2'd1,
    MRX_DONE = 2'd2
  } mrx_state_e;

endpackage

// File: rtl/mrx_rst_sync.sv
module mrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/mrx_popcnt.sv
module mrx_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);

  logic [CW-1:0] part [W+1];

  assign part[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(bits[g]);
  end

  assign count = part[W];

endmodule

// File: rtl/mrx_pick_hi.sv
module mrx_pick_hi #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);

  logic [W:0] above;

  assign above[W] = 1'b0;

  for (genvar g = W - 1; g >= 0; g--) begin : g_scan
    assign above[g]  = above[g+1] | bits[g];
    assign onehot[g] = bits[g] & ~above[g+1];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) begin
        idx = idx | IW'(i);
      end
    end
  end

endmodule

// File: rtl/mrx_rules.sv
module mrx_rules #(
  parameter int NREG   = 16,
  parameter int IDXW   = $clog2(NREG),
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic [NREG-1:0] mask,
  input  logic [IDXW-1:0] rn,
  input  logic            is_load,
  input  logic            want_wb,
  output logic            bad
);

  logic empty_list;
  logic base_is_pc;
  logic lists_sp;
  logic store_pc;
  logic load_lr_pc;
  logic wb_self;

  always_comb begin
    empty_list = ~|mask;
    base_is_pc = (rn == IDXW'(PC_IDX));
    lists_sp   = mask[SP_IDX];
    store_pc   = ~is_load & mask[PC_IDX];
    load_lr_pc = is_load & mask[LR_IDX] & mask[PC_IDX];
    wb_self    = want_wb & mask[rn];
    bad        = empty_list | base_is_pc | lists_sp | store_pc | load_lr_pc | wb_self;
  end

endmodule

// File: rtl/mrx_seq.sv
module mrx_seq
  import mrx_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int STEP   = 4,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  localparam int IDXW  = $clog2(NREG),
  localparam int CNTW  = $clog2(NREG + 1),
  localparam int STEPS = $clog2(STEP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_mask,
  input  logic [AW-1:0]   cmd_base,
  input  logic [IDXW-1:0] cmd_rn,
  input  logic            cmd_load,
  input  logic            cmd_wb,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [IDXW-1:0] mem_idx,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_load,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic            fault,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_value,
  output logic            br_valid,
  output logic [AW-1:0]   br_target
);

  logic rst_n_s;

  mrx_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // command decode
  logic [CNTW-1:0] cmd_cnt;
  logic            cmd_bad;

  mrx_popcnt #(.W(NREG), .CW(CNTW)) u_cnt (
    .bits  (cmd_mask),
    .count (cmd_cnt)
  );

  mrx_rules #(
    .NREG   (NREG),
    .IDXW   (IDXW),
    .SP_IDX (SP_IDX),
    .LR_IDX (LR_IDX),
    .PC_IDX (PC_IDX)
  ) u_rules (
    .mask    (cmd_mask),
    .rn      (cmd_rn),
    .is_load (cmd_load),
    .want_wb (cmd_wb),
    .bad     (cmd_bad)
  );

  // state
  mrx_state_e      state_q, state_d;
  logic [NREG-1:0] left_q, left_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            load_q, wb_q;
  logic [AW-1:0]   wbval_q, wbval_d;
  logic            fault_q, fault_d;
  logic            brv_q, brv_d;
  logic [AW-1:0]   brt_q, brt_d;

  logic [IDXW-1:0] pick_idx;
  logic [NREG-1:0] pick_oh;

  mrx_pick_hi #(.W(NREG), .IW(IDXW)) u_pick (
    .bits   (left_q),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  logic accept;
  logic hs;
  logic hs_pc;
  logic en_cmd;
  logic en_walk;
  logic en_res;
  logic [AW-1:0] base_al;

  always_comb begin
    accept  = (state_q == MRX_IDLE) & cmd_valid;
    hs      = (state_q == MRX_XFER) & mem_ready;
    hs_pc   = hs & load_q & (pick_idx == IDXW'(PC_IDX));
    en_cmd  = accept;
    en_walk = accept | hs;
    en_res  = accept | hs_pc;
    base_al = {cmd_base[AW-1:2], 2'b00};
  end

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    addr_d  = addr_q;
    wbval_d = wbval_q;
    fault_d = fault_q;
    brv_d   = brv_q;
    brt_d   = brt_q;
    unique case (state_q)
      MRX_IDLE: begin
        if (accept) begin
          left_d  = cmd_mask;
          addr_d  = base_al;
          wbval_d = base_al - ((AW'(cmd_cnt) - AW'(1)) << STEPS);
          fault_d = cmd_bad;
          brv_d   = 1'b0;
          brt_d   = '0;
          state_d = cmd_bad ? MRX_DONE : MRX_XFER;
        end
      end
      MRX_XFER: begin
        if (hs) begin
          left_d = left_q & ~pick_oh;
          addr_d = addr_q - AW'(STEP);
          if (hs_pc) begin
            fault_d = ~mem_rdata[0];
            brv_d   = mem_rdata[0];
            brt_d   = AW'({mem_rdata[DW-1:1], 1'b0});
          end
          if ((left_q & ~pick_oh) == '0) begin
            state_d = MRX_DONE;
          end
        end
      end
      MRX_DONE: begin
        state_d = MRX_IDLE;
      end
      default: begin
        state_d = MRX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= MRX_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      left_q <= '0;
      addr_q <= '0;
    end else if (en_walk) begin
      left_q <= left_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      wbval_q <= '0;
    end else if (en_cmd) begin
      load_q  <= cmd_load;
      wb_q    <= cmd_wb;
      wbval_q <= wbval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fault_q <= 1'b0;
      brv_q   <= 1'b0;
      brt_q   <= '0;
    end else if (en_res) begin
      fault_q <= fault_d;
      brv_q   <= brv_d;
      brt_q   <= brt_d;
    end
  end

  // outputs
  always_comb begin
    cmd_ready = (state_q == MRX_IDLE);
    mem_valid = (state_q == MRX_XFER);
    mem_idx   = pick_idx;
    mem_addr  = addr_q;
    mem_load  = load_q;
    done      = (state_q == MRX_DONE);
    fault     = done & fault_q;
    wb_valid  = done & wb_q & ~fault_q;
    wb_value  = wbval_q;
    br_valid  = done & brv_q & ~fault_q;
    br_target = brt_q;
  end

endmodule

// File: rtl/mrx_seq_chk.sv
module mrx_seq_chk #(
  parameter int NREG   = 16,
  parameter int AW     = 32,
  parameter int STEP   = 4,
  parameter int SP_IDX = 13,
  localparam int IDXW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [IDXW-1:0] mem_idx,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_load,
  input logic            done,
  input logic            fault,
  input logic            wb_valid,
  input logic            br_valid,
  input logic [AW-1:0]   br_target
);

  logic            seen_q;
  logic [AW-1:0]   prev_addr_q;
  logic [IDXW-1:0] prev_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_addr_q <= '0;
      prev_idx_q  <= '0;
    end else if (done) begin
      seen_q <= 1'b0;
    end else if (mem_valid && mem_ready) begin
      seen_q      <= 1'b1;
      prev_addr_q <= mem_addr;
      prev_idx_q  <= mem_idx;
    end
  end

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_valid && !done));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_idx) && $stable(mem_addr) && $stable(mem_load)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && seen_q) |-> (mem_addr == prev_addr_q - AW'(STEP)));

  // R2
  idx_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && seen_q) |-> (mem_idx < prev_idx_q));

  // R8
  no_sp_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_idx != IDXW'(SP_IDX)));

  // R11
  br_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (done && !fault && !br_target[0]));

  // R6
  wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (done && !fault));

endmodule

bind mrx_seq mrx_seq_chk #(
  .NREG   (NREG),
  .AW     (AW),
  .STEP   (STEP),
  .SP_IDX (SP_IDX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_idx   (mem_idx),
  .mem_addr  (mem_addr),
  .mem_load  (mem_load),
  .done      (done),
  .fault     (fault),
  .wb_valid  (wb_valid),
  .br_valid  (br_valid),
  .br_target (br_target)
);

// File: tb/tb_mrx_seq.sv
module tb_mrx_seq;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [15:0] cmd_mask;
  logic [31:0] cmd_base;
  logic [3:0]  cmd_rn;
  logic        cmd_load;
  logic        cmd_wb;
  logic        mem_valid;
  logic        mem_ready;
  logic [3:0]  mem_idx;
  logic [31:0] mem_addr;
  logic        mem_load;
  logic [31:0] mem_rdata;
  logic        done;
  logic        fault;
  logic        wb_valid;
  logic [31:0] wb_value;
  logic        br_valid;
  logic [31:0] br_target;

  mrx_seq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_mask  (cmd_mask),
    .cmd_base  (cmd_base),
    .cmd_rn    (cmd_rn),
    .cmd_load  (cmd_load),
    .cmd_wb    (cmd_wb),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_idx   (mem_idx),
    .mem_addr  (mem_addr),
    .mem_load  (mem_load),
    .mem_rdata (mem_rdata),
    .done      (done),
    .fault     (fault),
    .wb_valid  (wb_valid),
    .wb_value  (wb_value),
    .br_valid  (br_valid),
    .br_target (br_target)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // memory data source
  logic [31:0] pc_word;
  always_comb begin
    if (mem_idx == 4'd15) mem_rdata = pc_word;
    else                  mem_rdata = mem_addr ^ 32'hA5A5_0000;
  end

  // ready source
  bit        rdy_all;
  logic [7:0] lfsr;
  initial begin
    mem_ready = 1'b0;
    lfsr = 8'hB7;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = rdy_all ? 1'b1 : lfsr[0];
    end
  end

  // reference model
  typedef struct {
    int          idx;
    logic [31:0] addr;
  } xfer_t;

  xfer_t       q[$];
  bit          model_on;
  bit          m_idle = 1'b1;
  bit          m_done, m_fault, m_wbv, m_brv;
  logic [31:0] m_wbval, m_brt;
  bit          m_load;
  bit          p_wb, p_fault, p_brv;
  logic [31:0] p_wbval, p_brt;
  string       cur_req = "R7";

  function automatic bit rule_bad(logic [15:0] m, logic [3:0] rn, bit ld, bit wb);
    if (m == 16'h0) return 1'b1;
    if (rn == 4'd15) return 1'b1;
    if (m[13]) return 1'b1;
    if (!ld && m[15]) return 1'b1;
    if (ld && m[14] && m[15]) return 1'b1;
    if (wb && m[rn]) return 1'b1;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      bit stall;
      chk(cmd_ready === m_idle, "R1", "cmd_ready", 32'(cmd_ready), 32'(m_idle));
      chk(mem_valid === (q.size() > 0), "R2", "mem_valid", 32'(mem_valid), 32'(q.size() > 0));
      if (q.size() > 0) begin
        chk(mem_idx === 4'(q[0].idx), "R2", "mem_idx", 32'(mem_idx), 32'(q[0].idx));
        chk(mem_addr === q[0].addr, "R3", "mem_addr", mem_addr, q[0].addr);
        chk(mem_load === m_load, "R12", "mem_load", 32'(mem_load), 32'(m_load));
      end
      chk(done === m_done, "R5", "done", 32'(done), 32'(m_done));
      chk(fault === m_fault, cur_req, "fault", 32'(fault), 32'(m_fault));
      chk(wb_valid === m_wbv, "R6", "wb_valid", 32'(wb_valid), 32'(m_wbv));
      if (m_wbv) chk(wb_value === m_wbval, "R6", "wb_value", wb_value, m_wbval);
      chk(br_valid === m_brv, "R11", "br_valid", 32'(br_valid), 32'(m_brv));
      if (m_brv) chk(br_target === m_brt, "R11", "br_target", br_target, m_brt);

      stall = (q.size() > 0) && !mem_ready;
      if (m_done) begin
        m_done = 0; m_fault = 0; m_wbv = 0; m_brv = 0;
        m_idle = 1;
      end else if (m_idle && cmd_valid) begin
        m_idle = 0;
        m_load = cmd_load;
        if (rule_bad(cmd_mask, cmd_rn, cmd_load, cmd_wb)) begin
          m_done = 1; m_fault = 1;
        end else begin
          logic [31:0] a;
          int k;
          a = {cmd_base[31:2], 2'b00};
          k = 0;
          for (int i = 15; i >= 0; i--) begin
            if (cmd_mask[i]) begin
              q.push_back('{idx: i, addr: a - 32'(4 * k)});
              k++;
            end
          end
          p_wb = cmd_wb;
          p_wbval = a - 32'(4 * (k - 1));
          p_fault = 0; p_brv = 0; p_brt = 0;
        end
      end else if (q.size() > 0 && mem_ready) begin
        xfer_t f;
        f = q.pop_front();
        if (m_load && f.idx == 15) begin
          if (mem_rdata[0]) begin
            p_brv = 1; p_brt = mem_rdata & 32'hFFFF_FFFE;
          end else begin
            p_fault = 1;
          end
        end
        if (q.size() == 0) begin
          m_done  = 1;
          m_fault = p_fault;
          m_wbv   = p_wb && !p_fault;
          m_wbval = p_wbval;
          m_brv   = p_brv && !p_fault;
          m_brt   = p_brt;
        end
      end
      if (stall && q.size() > 0) begin
        // R4: request held across stall is covered by the next compare
        total = total;
      end
    end
  end

  task automatic run_cmd(input logic [15:0] m, input logic [31:0] base,
                         input logic [3:0] rn, input bit ld, input bit wb,
                         input logic [31:0] pcw, input string req, input bit poke);
    @(posedge clk); #1;
    while (!cmd_ready) begin @(posedge clk); #1; end
    cur_req   = req;
    pc_word   = pcw;
    cmd_mask  = m; cmd_base = base; cmd_rn = rn; cmd_load = ld; cmd_wb = wb;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (poke) begin
      // R1: a command offered mid-transfer must not be taken
      cmd_mask = 16'h00F0; cmd_base = 32'h0000_8000; cmd_rn = 4'd2;
      cmd_load = ~ld; cmd_wb = 1'b1; cmd_valid = 1'b1;
      repeat (2) begin @(posedge clk); #1; end
      cmd_valid = 1'b0;
    end
    do @(negedge clk); while (done !== 1'b1);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mask = '0; cmd_base = '0;
    cmd_rn = '0; cmd_load = 1'b0; cmd_wb = 1'b0; pc_word = '0; rdy_all = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R1", "reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk(mem_valid === 1'b0, "R2", "reset mem_valid", 32'(mem_valid), 32'd0);
    chk(done === 1'b0, "R5", "reset done", 32'(done), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 model_on = 1'b1;

    // R2 R3 R12: load, no writeback
    run_cmd(16'h0205, 32'h0000_1000, 4'd8, 1, 0, 0, "R2", 0);
    // R6 R3: store with writeback, unaligned base
    run_cmd(16'h1878, 32'h0000_2003, 4'd1, 0, 1, 0, "R6", 0);
    rdy_all = 1'b0;
    // R4: same with stalls, plus R1 mid-transfer command
    run_cmd(16'h1878, 32'h0000_3001, 4'd1, 0, 1, 0, "R4", 1);
    // R11: load into 15 with good target
    run_cmd(16'h8013, 32'h0000_4000, 4'd2, 1, 1, 32'h0800_1235, "R11", 0);
    // R11: bad target bit 0
    run_cmd(16'h8003, 32'h0000_4100, 4'd2, 1, 1, 32'h0800_1234, "R11", 0);
    // full list walk
    run_cmd(16'h9FFF, 32'h0001_0040, 4'd14, 1, 0, 32'h0000_0101, "R3", 0);
    // single register with writeback: value equals base
    run_cmd(16'h0010, 32'h0000_5008, 4'd3, 0, 1, 0, "R6", 0);
    rdy_all = 1'b1;
    // R7 empty list
    run_cmd(16'h0000, 32'h0000_6000, 4'd0, 1, 0, 0, "R7", 0);
    // R8 base index 15, list with 13
    run_cmd(16'h0003, 32'h0000_6000, 4'd15, 1, 0, 0, "R8", 0);
    run_cmd(16'h2001, 32'h0000_6000, 4'd4, 0, 0, 0, "R8", 0);
    // R9 store with 15, load with 14 and 15
    run_cmd(16'h8001, 32'h0000_6000, 4'd4, 0, 0, 0, "R9", 0);
    run_cmd(16'hC000, 32'h0000_6000, 4'd4, 1, 0, 0, "R9", 0);
    // R10 writeback with base in list
    run_cmd(16'h0230, 32'h0000_6000, 4'd5, 1, 1, 0, "R10", 0);
    // legal again after faults
    run_cmd(16'h4001, 32'h0000_7000, 4'd3, 1, 1, 0, "R6", 0);

    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule